// File: doc/BRIEF.md
# Lockable Direct-Mapped Instruction Cache

This block sits on the code side of a processor, between the instruction fetch port and a slower program memory. In cache mode it keeps recently fetched code in a direct-mapped store of 256 lines, each holding four words. A fetch that hits is answered on the next cycle. A fetch that misses stalls while the whole line is read from backing memory one word at a time, and is then answered.

A write port lets a debugger place single words, typically breakpoint opcodes, into a line and pin that line. A pinned line is never evicted by a refill, so soft breakpoints stay in place while code keeps running from slow memory. A fetch that collides with a pinned line reads its one word straight from backing memory and leaves the pinned line alone.

A mode input turns the same storage into 1280 words of directly addressed code RAM. In that mode the write port loads words into the RAM. Every change of mode wipes all line state, both the valid bits and the pins.

Top module: `lockable_icache`

## Requirements
- R1: After reset `fetchValid` and `memReq` are low, `fetchRdy` is high, and every line is invalid, so the first cache-mode fetch misses.
- R2: In cache mode a word address splits into bits [1:0] as the word within the line, bits [9:2] as the line index, and the bits above as the tag. Two addresses with the same index and different tags compete for one line.
- R3: A miss to an unpinned line issues exactly four backing reads, one at a time, to the line's words 0, 1, 2 and 3 in that order. `fetchValid` rises in the cycle after the fourth `memValid` and carries the requested word.
- R4: A fetch that hits raises `fetchValid` in the cycle after it is accepted, with the stored word, and makes no backing read.
- R5: A miss to a valid, unpinned line with a different tag replaces that line. The former contents then miss again.
- R6: A pin write in cache mode stores `lockData` at the word named by `lockAddr`, gives that line the address's tag, and marks it valid and pinned. A later fetch of that address hits and returns the stored word.
- R7: A miss whose line is pinned makes a single backing read of the fetch address. It answers in the cycle after `memValid` with that data and leaves the pinned line intact.
- R8: An unpin write clears the pin of the line named by `lockAddr`, after which a conflicting miss refills that line normally.
- R9: In RAM mode a fetch of an address below 1280 returns the word there one cycle later and never requests backing memory. Addresses at or above 1280 read as zero. The pin write port stores `lockData` at `lockAddr` when that address is below 1280.
- R10: A change of `cfgSramMode` invalidates every line and clears every pin. `fetchRdy` is low in the cycle the change is seen.
- R11: `fetchRdy` is low while a refill or a direct backing read is in progress, and in any cycle with a pin or unpin write. Such writes win over a fetch presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgSramMode | input | 1 | 0 selects cache mode, 1 selects RAM mode |
| fetchReq | input | 1 | Fetch request, taken when `fetchRdy` is high |
| fetchAddr | input | ADDR_W | Word address of the fetch |
| fetchRdy | output | 1 | Ready to take a fetch or write this cycle |
| fetchValid | output | 1 | One-cycle pulse with fetch data |
| fetchData | output | DATA_W | Fetched word |
| lockWe | input | 1 | Pin write (cache mode) or RAM write (RAM mode) |
| unlockWe | input | 1 | Clear the pin of a line |
| lockAddr | input | ADDR_W | Word address for pin, unpin or RAM write |
| lockData | input | DATA_W | Word stored by a pin or RAM write |
| memReq | output | 1 | Backing read request, held until `memValid` |
| memAddr | output | ADDR_W | Backing read word address |
| memValid | input | 1 | Backing read data valid, one cycle |
| memData | input | DATA_W | Backing read data |

## Verification
The bench uses the default parameters: 16-bit words and addresses, 256 lines of four words, and 1280 RAM words. With these values the top line index, tags that differ only in the bits above the index, and the last RAM word 1279 with its neighbour 1280 just beyond it can all be reached by plain directed addresses. The backing memory model answers after a fixed delay with a word computed from its address. This lets the bench check the order of refill addresses and where the response lands relative to the final backing beat.

// File: rtl/icache_pkg.sv
package icache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REFILL = 2'd1,
    ST_BYPASS = 2'd2
  } ctlState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic captureReq;   // latch the accepted fetch address
    logic readArr;      // load output word from storage
    logic cntClr;       // restart the refill word counter
    logic refillWr;     // write a returned backing word into the line
    logic captureMem;   // load output word from backing data
    logic setLine;      // mark the refilled line valid with its tag
    logic bypassSel;    // backing address is the raw fetch address
    logic lockWrite;    // pin write / RAM write
    logic unlock;       // clear a line's pin
    logic invalidate;   // wipe all valid and pin bits
  } dpStrobes_t;

endpackage

// File: rtl/icache_datapath.sv
module icache_datapath
  import icache_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 16,
  parameter int LINES      = 256,
  parameter int WPL        = 4,
  parameter int SRAM_WORDS = 1280
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        stb,
  input  logic              sramMode,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [ADDR_W-1:0] lockAddr,
  input  logic [DATA_W-1:0] lockData,
  input  logic [DATA_W-1:0] memData,
  output logic              lookupHit,
  output logic              lookupLocked,
  output logic              refillLast,
  output logic              cntMatch,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] fetchData
);

  localparam int OFF_W       = $clog2(WPL);
  localparam int IDX_W       = $clog2(LINES);
  localparam int CW          = OFF_W + IDX_W;
  localparam int TAG_W       = ADDR_W - CW;
  localparam int CACHE_WORDS = LINES * WPL;
  localparam int ARR_WORDS   = (SRAM_WORDS > CACHE_WORDS) ? SRAM_WORDS : CACHE_WORDS;
  localparam int ARR_AW      = $clog2(ARR_WORDS);
  localparam logic [ADDR_W-1:0] SRAM_LIMIT = ADDR_W'(SRAM_WORDS);
  localparam logic [OFF_W-1:0]  LAST_WORD  = OFF_W'(WPL - 1);

  logic [DATA_W-1:0] dataArr [ARR_WORDS];
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [LINES-1:0]  validBits;
  logic [LINES-1:0]  lockBits;
  logic [ADDR_W-1:0] reqAddr;
  logic [OFF_W-1:0]  fillCnt;
  logic [DATA_W-1:0] outData;

  // Field split of the three addresses in play
  logic [IDX_W-1:0] fIdx, lIdx, rIdx;
  logic [TAG_W-1:0] fTag, lTag, rTag;
  logic [ARR_AW-1:0] fArrIdx, lArrIdx, rArrIdx;
  logic fInRange, lInRange;

  always_comb begin
    fIdx = fetchAddr[OFF_W +: IDX_W];
    lIdx = lockAddr[OFF_W +: IDX_W];
    rIdx = reqAddr[OFF_W +: IDX_W];
    fTag = fetchAddr[ADDR_W-1 -: TAG_W];
    lTag = lockAddr[ADDR_W-1 -: TAG_W];
    rTag = reqAddr[ADDR_W-1 -: TAG_W];
    fInRange = fetchAddr < SRAM_LIMIT;
    lInRange = lockAddr < SRAM_LIMIT;
    fArrIdx = sramMode ? fetchAddr[ARR_AW-1:0] : ARR_AW'(fetchAddr[CW-1:0]);
    lArrIdx = sramMode ? lockAddr[ARR_AW-1:0]  : ARR_AW'(lockAddr[CW-1:0]);
    rArrIdx = ARR_AW'({rIdx, fillCnt});
  end

  // Lookup on the incoming fetch address
  always_comb begin
    lookupHit    = sramMode | (validBits[fIdx] && (tagArr[fIdx] == fTag));
    lookupLocked = !sramMode && lockBits[fIdx];
    refillLast   = (fillCnt == LAST_WORD);
    cntMatch     = (fillCnt == reqAddr[OFF_W-1:0]);
    memAddr      = stb.bypassSel ? reqAddr : {reqAddr[ADDR_W-1:OFF_W], fillCnt};
    fetchData    = outData;
  end

  // Word storage, shared by both modes
  always_ff @(posedge clk) begin
    if (stb.refillWr)
      dataArr[rArrIdx] <= memData;
    else if (stb.lockWrite && (!sramMode || lInRange))
      dataArr[lArrIdx] <= lockData;
  end

  always_ff @(posedge clk) begin
    if (stb.setLine)
      tagArr[rIdx] <= rTag;
    else if (stb.lockWrite && !sramMode)
      tagArr[lIdx] <= lTag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits <= '0;
      lockBits  <= '0;
    end else if (stb.invalidate) begin
      validBits <= '0;
      lockBits  <= '0;
    end else begin
      if (stb.setLine)
        validBits[rIdx] <= 1'b1;
      if (stb.lockWrite && !sramMode) begin
        validBits[lIdx] <= 1'b1;
        lockBits[lIdx]  <= 1'b1;
      end
      if (stb.unlock && !sramMode)
        lockBits[lIdx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr <= '0;
      fillCnt <= '0;
      outData <= '0;
    end else begin
      if (stb.captureReq)
        reqAddr <= fetchAddr;
      if (stb.cntClr)
        fillCnt <= '0;
      else if (stb.refillWr)
        fillCnt <= fillCnt + 1'b1;
      if (stb.readArr)
        outData <= (sramMode && !fInRange) ? '0 : dataArr[fArrIdx];
      else if (stb.captureMem)
        outData <= memData;
    end
  end

  // A refill must never land in a pinned line
  p_refill_unpinned_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.refillWr |-> !lockBits[rIdx]);

  // A mode change leaves no valid or pinned line behind
  p_flush_all_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.invalidate |=> (validBits == '0 && lockBits == '0));

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgSramMode,
  input  logic       fetchReq,
  input  logic       lockWe,
  input  logic       unlockWe,
  input  logic       memValid,
  input  logic       lookupHit,
  input  logic       lookupLocked,
  input  logic       refillLast,
  input  logic       cntMatch,
  output dpStrobes_t stb,
  output logic       sramMode,
  output logic       fetchRdy,
  output logic       fetchValid,
  output logic       memReq
);

  ctlState_e state, nextState;
  logic      modeReg;
  logic      outValid, respNext;
  logic      modeChange;

  assign modeChange = (cfgSramMode != modeReg);
  assign sramMode   = modeReg;
  assign fetchValid = outValid;
  assign memReq     = (state == ST_REFILL) || (state == ST_BYPASS);
  assign fetchRdy   = (state == ST_IDLE) && !modeChange && !lockWe && !unlockWe;

  always_comb begin
    stb       = '0;
    nextState = state;
    respNext  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (modeChange) begin
          stb.invalidate = 1'b1;
        end else if (lockWe) begin
          stb.lockWrite = 1'b1;
        end else if (unlockWe) begin
          stb.unlock = 1'b1;
        end else if (fetchReq) begin
          stb.captureReq = 1'b1;
          stb.cntClr     = 1'b1;
          if (lookupHit) begin
            stb.readArr = 1'b1;
            respNext    = 1'b1;
          end else if (lookupLocked) begin
            nextState = ST_BYPASS;
          end else begin
            nextState = ST_REFILL;
          end
        end
      end
      ST_REFILL: begin
        if (memValid) begin
          stb.refillWr   = 1'b1;
          stb.captureMem = cntMatch;
          if (refillLast) begin
            stb.setLine = 1'b1;
            respNext    = 1'b1;
            nextState   = ST_IDLE;
          end
        end
      end
      ST_BYPASS: begin
        stb.bypassSel = 1'b1;
        if (memValid) begin
          stb.captureMem = 1'b1;
          respNext       = 1'b1;
          nextState      = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    // A mode change while busy abandons the fetch
    if (modeChange && state != ST_IDLE) begin
      stb            = '0;
      stb.invalidate = 1'b1;
      respNext       = 1'b0;
      nextState      = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      modeReg  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      state    <= nextState;
      modeReg  <= cfgSramMode;
      outValid <= respNext;
    end
  end

  // Hit answers on the next cycle without touching backing memory
  p_hit_next_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && fetchRdy && lookupHit) |=> (fetchValid && !memReq));

  // Miss stalls and goes to backing memory
  p_miss_stalls_r3: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && fetchRdy && !lookupHit) |=> (memReq && !fetchValid && !fetchRdy));

  // RAM mode always resolves locally
  p_sram_local_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sramMode && fetchRdy) |-> lookupHit);

  // Writes take the slot ahead of fetches
  p_write_blocks_r11: assert property (@(posedge clk) disable iff (!rstN)
    (lockWe || unlockWe) |-> !fetchRdy);

endmodule

// File: rtl/lockable_icache.sv
module lockable_icache
  import icache_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 16,
  parameter int LINES      = 256,
  parameter int WPL        = 4,
  parameter int SRAM_WORDS = 1280
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgSramMode,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchRdy,
  output logic              fetchValid,
  output logic [DATA_W-1:0] fetchData,
  input  logic              lockWe,
  input  logic              unlockWe,
  input  logic [ADDR_W-1:0] lockAddr,
  input  logic [DATA_W-1:0] lockData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [DATA_W-1:0] memData
);

  dpStrobes_t stb;
  logic sramMode, lookupHit, lookupLocked, refillLast, cntMatch;

  icache_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgSramMode  (cfgSramMode),
    .fetchReq     (fetchReq),
    .lockWe       (lockWe),
    .unlockWe     (unlockWe),
    .memValid     (memValid),
    .lookupHit    (lookupHit),
    .lookupLocked (lookupLocked),
    .refillLast   (refillLast),
    .cntMatch     (cntMatch),
    .stb          (stb),
    .sramMode     (sramMode),
    .fetchRdy     (fetchRdy),
    .fetchValid   (fetchValid),
    .memReq       (memReq)
  );

  icache_datapath #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .LINES      (LINES),
    .WPL        (WPL),
    .SRAM_WORDS (SRAM_WORDS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .sramMode     (sramMode),
    .fetchAddr    (fetchAddr),
    .lockAddr     (lockAddr),
    .lockData     (lockData),
    .memData      (memData),
    .lookupHit    (lookupHit),
    .lookupLocked (lookupLocked),
    .refillLast   (refillLast),
    .cntMatch     (cntMatch),
    .memAddr      (memAddr),
    .fetchData    (fetchData)
  );

endmodule

// File: tb/lockable_icache_test.sv
`timescale 1ns/1ps
module lockable_icache_test;

  localparam int MEM_LAT = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgSramMode = 1'b0;
  logic        fetchReq = 1'b0;
  logic [15:0] fetchAddr = '0;
  logic        fetchRdy, fetchValid;
  logic [15:0] fetchData;
  logic        lockWe = 1'b0, unlockWe = 1'b0;
  logic [15:0] lockAddr = '0, lockData = '0;
  logic        memReq;
  logic [15:0] memAddr;
  logic        memValid;
  logic [15:0] memData;

  int checks = 0;
  int errors = 0;
  int respCount = 0;
  int waitCnt = 0;
  logic [15:0] logAddr [64];

  always #2 clk = ~clk;

  lockable_icache uut (
    .clk(clk), .rstN(rstN), .cfgSramMode(cfgSramMode),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchRdy(fetchRdy),
    .fetchValid(fetchValid), .fetchData(fetchData),
    .lockWe(lockWe), .unlockWe(unlockWe), .lockAddr(lockAddr), .lockData(lockData),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData)
  );

  function automatic logic [15:0] memFn(input logic [15:0] a);
    return (a * 16'd40503) ^ 16'h5A5A;
  endfunction

  // Backing memory model
  always @(negedge clk) begin
    memValid = 1'b0;
    if (!rstN) begin
      memData = '0;
      waitCnt = 0;
    end else if (memReq) begin
      if (waitCnt == MEM_LAT) begin
        memValid = 1'b1;
        memData  = memFn(memAddr);
        logAddr[respCount % 64] = memAddr;
        respCount++;
        waitCnt = 0;
      end else begin
        waitCnt++;
      end
    end else begin
      waitCnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Issue one fetch; report data, latency, backing beats, last beat position
  task automatic doFetch(input logic [15:0] addr, output logic [15:0] data,
                         output int lat, output int beats, output int lastBeat,
                         output int firstLog, output int rdyBusy);
    firstLog = respCount;
    lat = 0; lastBeat = -1; rdyBusy = 0; data = '0;
    @(negedge clk);
    fetchReq = 1'b1;
    fetchAddr = addr;
    #1;
    chk(fetchRdy == 1'b1, "R11 ready when idle", fetchRdy, 1);
    @(negedge clk);
    fetchReq = 1'b0;
    for (int i = 1; i <= 60; i++) begin
      #1;
      if (memValid) lastBeat = i;
      if (fetchValid) begin
        lat = i;
        data = fetchData;
        break;
      end
      if (memReq && fetchRdy) rdyBusy++;
      @(negedge clk);
    end
    if (lat == 0) chk(1'b0, "watchdog fetch timeout", 0, 1);
    beats = respCount - firstLog;
  endtask

  task automatic doWrite(input bit unpin, input logic [15:0] addr, input logic [15:0] val);
    @(negedge clk);
    lockWe = !unpin;
    unlockWe = unpin;
    lockAddr = addr;
    lockData = val;
    @(negedge clk);
    lockWe = 1'b0;
    unlockWe = 1'b0;
  endtask

  task automatic setMode(input bit m);
    @(negedge clk);
    cfgSramMode = m;
    #1;
    chk(fetchRdy == 1'b0, "R10 not ready on mode change", fetchRdy, 0);
    @(negedge clk);
  endtask

  // Miss with full refill, checking order and response timing
  task automatic expectRefill(input logic [15:0] addr, input string req);
    logic [15:0] d; int lat, beats, lastBeat, firstLog, busy;
    doFetch(addr, d, lat, beats, lastBeat, firstLog, busy);
    chk(d == memFn(addr), req, d, memFn(addr));
    chk(beats == 4, {req, " four beats"}, beats, 4);
    for (int k = 0; k < 4; k++)
      chk(logAddr[(firstLog + k) % 64] == {addr[15:2], 2'(k)}, {"R3 order ", req},
          logAddr[(firstLog + k) % 64], {addr[15:2], 2'(k)});
    chk(lat == lastBeat + 1, "R3 response after last beat", lat, lastBeat + 1);
    chk(busy == 0, "R11 not ready during refill", busy, 0);
  endtask

  task automatic expectHit(input logic [15:0] addr, input logic [15:0] exp, input string req);
    logic [15:0] d; int lat, beats, lastBeat, firstLog, busy;
    doFetch(addr, d, lat, beats, lastBeat, firstLog, busy);
    chk(d == exp, req, d, exp);
    chk(lat == 1, {req, " latency"}, lat, 1);
    chk(beats == 0, {req, " no backing read"}, beats, 0);
  endtask

  task automatic testReset();
    chk(fetchValid == 1'b0, "R1 fetchValid", fetchValid, 0);
    chk(memReq == 1'b0, "R1 memReq", memReq, 0);
    chk(fetchRdy == 1'b1, "R1 fetchRdy", fetchRdy, 1);
  endtask

  task automatic testMissHit();
    expectRefill(16'h1236, "R1 cold miss");
    expectHit(16'h1236, memFn(16'h1236), "R4 hit");
    expectHit(16'h1235, memFn(16'h1235), "R4 hit same line");
    expectRefill(16'h03FF, "R2 top index");
    expectHit(16'h03FC, memFn(16'h03FC), "R2 top index hit");
  endtask

  task automatic testConflict();
    expectRefill(16'h1636, "R5 conflict replaces");
    expectRefill(16'h1236, "R5 evicted line misses");
  endtask

  task automatic testPin();
    logic [15:0] d; int lat, beats, lastBeat, firstLog, busy;
    doWrite(1'b0, 16'h2010, 16'hBEEF);
    expectHit(16'h2010, 16'hBEEF, "R6 pinned word");
    doFetch(16'h2410, d, lat, beats, lastBeat, firstLog, busy);
    chk(d == memFn(16'h2410), "R7 bypass data", d, memFn(16'h2410));
    chk(beats == 1, "R7 single beat", beats, 1);
    chk(logAddr[firstLog % 64] == 16'h2410, "R7 bypass address", logAddr[firstLog % 64], 16'h2410);
    chk(lat == lastBeat + 1, "R7 response timing", lat, lastBeat + 1);
    expectHit(16'h2010, 16'hBEEF, "R7 pinned line intact");
    doWrite(1'b1, 16'h2010, 16'h0000);
    expectRefill(16'h2410, "R8 unpinned line refills");
    expectRefill(16'h2010, "R8 old pinned word gone");
  endtask

  task automatic testPriority();
    @(negedge clk);
    fetchReq = 1'b1; fetchAddr = 16'h1636;
    lockWe = 1'b1; lockAddr = 16'h3004; lockData = 16'h7777;
    #1;
    chk(fetchRdy == 1'b0, "R11 write blocks fetch", fetchRdy, 0);
    @(negedge clk);
    fetchReq = 1'b0; lockWe = 1'b0;
    #1;
    chk(fetchValid == 1'b0 && memReq == 1'b0, "R11 fetch not taken", {fetchValid, memReq}, 0);
    expectHit(16'h3004, 16'h7777, "R11 write applied");
  endtask

  task automatic testSram();
    doWrite(1'b0, 16'h2010, 16'hBEEF);   // pin a line before switching
    setMode(1'b1);
    doWrite(1'b0, 16'd1279, 16'h1234);
    doWrite(1'b0, 16'd5, 16'hAAAA);
    expectHit(16'd1279, 16'h1234, "R9 last RAM word");
    expectHit(16'd5, 16'hAAAA, "R9 low RAM word");
    expectHit(16'd1280, 16'h0000, "R9 beyond RAM");
    setMode(1'b0);
    expectRefill(16'h1636, "R10 lines invalidated");
    expectRefill(16'h2410, "R10 pins cleared");
  endtask

  initial begin
    #(200000 * 4);
    chk(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    testReset();
    testMissHit();
    testConflict();
    testPin();
    testPriority();
    testSram();
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule